// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block keeps a ring of in-flight instruction slots in program order and retires up to `WIDTH` of them per clock from the oldest end. When a slot is allocated it is tagged with a kind, a sequence number and the address of the instruction that follows it. Each retirement moves the architectural program counter pair forward and reports the sequence number back to the rest of the pipeline. Completion, fault and squash information arrive per slot from outside.

The slot at the head may need help before it can leave. An unexecuted serializing slot (non-speculative, store-conditional or barrier) is handed back for execution only when it leads the commit group and the store buffer is empty. An uncached load is handed back with no such condition. A completed slot that carries a fault stops commit. Once the store buffer is empty and the slot leads the group, the block enters a trap-pending state. A single-cycle trap-squash pulse follows after a programmable number of cycles, and that pulse empties the ring.

Top module: `rob_commit`

## Requirements
- R1: `alloc_ready` is high exactly when the ring is not full and no trap is pending. An accepted allocation goes into slot `alloc_idx`, which then advances by one modulo `DEPTH`.
- R2: Each clock retires completed, non-faulting slots in order from the head, at most `WIDTH` of them. Retirement stops at the first slot that is not ready. `retire_cnt` shows the count on the following cycle.
- R3: A squashed slot at the head is removed without retiring and without counting toward `WIDTH`. This applies even when the group is already full.
- R4: On the cycle after a retirement, `done_valid` is high and `done_seq` holds the sequence number of the youngest slot retired in that clock.
- R5: After reset, `arch_pc` equals `RESET_PC` and `arch_npc` equals `RESET_PC+INST_BYTES`. On each retirement, `arch_pc` takes the next-address of the youngest retired slot and `arch_npc` takes that value plus `INST_BYTES`.
- R6: Kind 2'b01 (or 2'b11) is serializing. An unexecuted, unreleased serializing slot reached by the walk is released only if nothing has retired in that clock and `stores_pending` is low. `rel_valid` and `rel_idx` report the release one cycle later. The slot is released at most once and retires after it completes.
- R7: Kind 2'b10 is an uncached load. When the walk reaches it unexecuted and unreleased, it is released at once, whatever the state of the stores and of the group. Kind 2'b00 is a plain slot that only waits for completion.
- R8: A completed slot whose completion carried `cmpl_fault` stops the walk. It sets `trap_pending` on the next cycle only if it leads the group and `stores_pending` is low.
- R9: While `trap_pending` is high, nothing retires or is released. `trap_squash` is high for one cycle, `trap_lat` clock edges after `trap_pending` rises. At that edge the ring empties and `trap_pending` falls.
- R10: `empty` and `full` follow from head and tail pointers that carry a wrap bit. The ring holds exactly `DEPTH` slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | 00 plain, 01/11 serializing, 10 uncached load |
| alloc_seq | input | SEQ_W | Sequence number of the new slot |
| alloc_npc | input | PC_W | Address of the instruction after it |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation uses |
| cmpl_valid | input | 1 | Slot finished executing |
| cmpl_idx | input | log2(DEPTH) | Slot that finished |
| cmpl_fault | input | 1 | The finished slot faulted |
| kill_valid | input | 1 | Mark a slot squashed |
| kill_idx | input | log2(DEPTH) | Slot to squash |
| stores_pending | input | 1 | Committed stores still await writeback |
| trap_lat | input | LAT_W | Cycles from trap-pending to trap squash |
| retire_cnt | output | log2(WIDTH+1) | Slots retired in the previous clock |
| done_valid | output | 1 | `done_seq` is fresh |
| done_seq | output | SEQ_W | Youngest retired sequence number |
| arch_pc | output | PC_W | Architectural program counter |
| arch_npc | output | PC_W | Architectural next program counter |
| rel_valid | output | 1 | A head slot was released for execution |
| rel_idx | output | log2(DEPTH) | Released slot |
| trap_pending | output | 1 | A trap is being sequenced |
| trap_squash | output | 1 | One-cycle trap squash pulse |
| full | output | 1 | Ring holds DEPTH slots |
| empty | output | 1 | Ring holds no slots |

## Verification
Several properties are checked on every cycle:
- the next-PC always stays one instruction ahead of the PC after a retirement;
- nothing retires while a trap is pending;
- the squash pulse leaves the ring empty;
- a serializing release or a trap entry never happens with stores pending or behind a retirement.

Only the bench scenarios can show that retirement order, `done_seq`, the release slot and the exact trap delay are right. They do this by comparing every output, every cycle, against a reference model of the ring. The model is driven by random allocation, completion, squash, fault and store-drain patterns, and by directed fill and drain phases.

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 2,
  parameter int SEQ_W = 16,
  parameter int PC_W = 32,
  parameter int INST_BYTES = 4,
  parameter int LAT_W = 4,
  parameter logic [PC_W-1:0] RESET_PC = 'h1000,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RC_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic [1:0]       alloc_kind,
  input  logic [SEQ_W-1:0] alloc_seq,
  input  logic [PC_W-1:0]  alloc_npc,
  output logic             alloc_ready,
  output logic [IDX_W-1:0] alloc_idx,
  input  logic             cmpl_valid,
  input  logic [IDX_W-1:0] cmpl_idx,
  input  logic             cmpl_fault,
  input  logic             kill_valid,
  input  logic [IDX_W-1:0] kill_idx,
  input  logic             stores_pending,
  input  logic [LAT_W-1:0] trap_lat,
  output logic [RC_W-1:0]  retire_cnt,
  output logic             done_valid,
  output logic [SEQ_W-1:0] done_seq,
  output logic [PC_W-1:0]  arch_pc,
  output logic [PC_W-1:0]  arch_npc,
  output logic             rel_valid,
  output logic [IDX_W-1:0] rel_idx,
  output logic             trap_pending,
  output logic             trap_squash,
  output logic             full,
  output logic             empty
);
  localparam int PW = IDX_W + 1;
  localparam logic [1:0] K_NORM = 2'b00;
  localparam logic [1:0] K_UNC = 2'b10;

  logic [PW-1:0]    head, tail, occ;
  logic [LAT_W-1:0] tcnt;
  logic [DEPTH-1:0] e_done, e_kill, e_flt, e_rel;
  logic [1:0]       e_kind [DEPTH];
  logic [SEQ_W-1:0] e_seq [DEPTH];
  logic [PC_W-1:0]  e_npc [DEPTH];
  logic             alloc_fire;

  assign occ = tail - head;
  assign empty = head == tail;
  assign full = (head[IDX_W] != tail[IDX_W]) && (head[IDX_W-1:0] == tail[IDX_W-1:0]);
  assign trap_squash = trap_pending && (tcnt == '0);
  assign alloc_ready = !full && !trap_pending;
  assign alloc_idx = tail[IDX_W-1:0];
  assign alloc_fire = alloc_valid && alloc_ready;

  logic [PW-1:0]    pop_n;
  logic [RC_W-1:0]  ret_n;
  logic             stop, rel_hit, take_trap;
  logic [IDX_W-1:0] rel_at, slot;
  logic [SEQ_W-1:0] last_seq;
  logic [PC_W-1:0]  last_npc;

  always_comb begin
    pop_n = '0;
    ret_n = '0;
    stop = 1'b0;
    rel_hit = 1'b0;
    take_trap = 1'b0;
    rel_at = '0;
    slot = '0;
    last_seq = '0;
    last_npc = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head[IDX_W-1:0] + IDX_W'(k);
      if (!stop && !trap_pending && (PW'(k) < occ)) begin
        if (e_kill[slot]) begin
          pop_n = pop_n + PW'(1);
        end else if (ret_n == RC_W'(WIDTH)) begin
          stop = 1'b1;
        end else if (e_done[slot] && e_flt[slot]) begin
          take_trap = (ret_n == '0) && !stores_pending;
          stop = 1'b1;
        end else if (e_done[slot]) begin
          pop_n = pop_n + PW'(1);
          ret_n = ret_n + RC_W'(1);
          last_seq = e_seq[slot];
          last_npc = e_npc[slot];
        end else begin
          if (e_kind[slot] != K_NORM && !e_rel[slot] &&
              (e_kind[slot] == K_UNC || (ret_n == '0 && !stores_pending))) begin
            rel_hit = 1'b1;
            rel_at = slot;
          end
          stop = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      tcnt <= '0;
      trap_pending <= 1'b0;
      retire_cnt <= '0;
      done_valid <= 1'b0;
      done_seq <= '0;
      arch_pc <= RESET_PC;
      arch_npc <= RESET_PC + PC_W'(INST_BYTES);
      rel_valid <= 1'b0;
      rel_idx <= '0;
      e_done <= '0;
      e_kill <= '0;
      e_flt <= '0;
      e_rel <= '0;
    end else begin
      retire_cnt <= ret_n;
      done_valid <= ret_n != '0;
      if (ret_n != '0) begin
        done_seq <= last_seq;
        arch_pc <= last_npc;
        arch_npc <= last_npc + PC_W'(INST_BYTES);
      end
      rel_valid <= rel_hit;
      if (rel_hit) rel_idx <= rel_at;
      if (trap_squash) begin
        head <= tail;
        trap_pending <= 1'b0;
      end else begin
        head <= head + pop_n;
        if (take_trap) begin
          trap_pending <= 1'b1;
          tcnt <= trap_lat;
        end else if (trap_pending) begin
          tcnt <= tcnt - LAT_W'(1);
        end
      end
      if (alloc_fire) tail <= tail + PW'(1);
      if (cmpl_valid) begin
        e_done[cmpl_idx] <= 1'b1;
        e_flt[cmpl_idx] <= cmpl_fault;
      end
      if (kill_valid) e_kill[kill_idx] <= 1'b1;
      if (rel_hit) e_rel[rel_at] <= 1'b1;
      if (alloc_fire) begin
        e_done[alloc_idx] <= 1'b0;
        e_kill[alloc_idx] <= 1'b0;
        e_flt[alloc_idx] <= 1'b0;
        e_rel[alloc_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      e_kind[alloc_idx] <= alloc_kind;
      e_seq[alloc_idx] <= alloc_seq;
      e_npc[alloc_idx] <= alloc_npc;
    end
  end

  p_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retire_cnt <= RC_W'(WIDTH));
  p_npc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> arch_npc == arch_pc + PC_W'(INST_BYTES));
  p_serial_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && e_kind[rel_idx] != K_NORM && e_kind[rel_idx] != K_UNC)
      |-> ($past(!stores_pending) && retire_cnt == '0));
  p_trap_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_pending) |-> ($past(!stores_pending) && retire_cnt == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pending |=> (retire_cnt == '0 && !rel_valid));
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_squash |=> (empty && !trap_pending));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
endmodule

// File: tb/rob_commit_bench.sv
`timescale 1ns/1ps
module rob_commit_bench;
  localparam int DEPTH = 8, WIDTH = 2, SEQ_W = 16, PC_W = 32, INST_BYTES = 4, LAT_W = 4;
  localparam logic [31:0] RST_PC = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready, cmpl_valid = 0, cmpl_fault = 0, kill_valid = 0;
  logic [1:0] alloc_kind = 0;
  logic [15:0] alloc_seq = 0, done_seq;
  logic [31:0] alloc_npc = 0, arch_pc, arch_npc;
  logic [2:0] alloc_idx, cmpl_idx = 0, kill_idx = 0, rel_idx;
  logic stores_pending = 0, done_valid, rel_valid, trap_pending, trap_squash, full, empty;
  logic [3:0] trap_lat = 0;
  logic [1:0] retire_cnt;

  rob_commit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SEQ_W(SEQ_W), .PC_W(PC_W),
               .INST_BYTES(INST_BYTES), .LAT_W(LAT_W), .RESET_PC(RST_PC)) u_rob_commit (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_kind(alloc_kind),
    .alloc_seq(alloc_seq), .alloc_npc(alloc_npc), .alloc_ready(alloc_ready),
    .alloc_idx(alloc_idx), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
    .cmpl_fault(cmpl_fault), .kill_valid(kill_valid), .kill_idx(kill_idx),
    .stores_pending(stores_pending), .trap_lat(trap_lat), .retire_cnt(retire_cnt),
    .done_valid(done_valid), .done_seq(done_seq), .arch_pc(arch_pc), .arch_npc(arch_npc),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .trap_pending(trap_pending),
    .trap_squash(trap_squash), .full(full), .empty(empty));

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int m_head = 0, m_occ = 0, m_tc = 0;
  bit m_pend = 0;
  bit md[DEPTH], mk[DEPTH], mf[DEPTH], mr[DEPTH];
  int mkind[DEPTH];
  logic [15:0] mseq[DEPTH];
  logic [31:0] mnpc[DEPTH];
  int x_ret = 0, x_ridx = 0, x_rkind = 0;
  bit x_dv = 0, x_rv = 0, x_killed = 0;
  logic [15:0] x_dseq = 0;
  logic [31:0] x_pc = RST_PC, x_npc = RST_PC + 4;
  logic [15:0] seq_ctr = 16'h100;

  function automatic bit m_squash_now();
    return m_pend && m_tc == 0;
  endfunction

  task automatic check_outputs();
    chk(x_killed ? "R3" : "R2", retire_cnt, x_ret);
    chk("R4", done_valid, x_dv);
    if (x_dv) chk("R4", done_seq, x_dseq);
    chk("R5", arch_pc, x_pc);
    chk("R5", arch_npc, x_npc);
    chk("R6", rel_valid, x_rv);
    if (x_rv) chk(x_rkind == 2 ? "R7" : "R6", rel_idx, x_ridx);
    chk("R8", trap_pending, m_pend);
    chk("R9", trap_squash, m_squash_now());
    chk("R1", alloc_ready, m_occ != DEPTH && !m_pend);
    chk("R1", alloc_idx, (m_head + m_occ) % DEPTH);
    chk("R10", full, m_occ == DEPTH);
    chk("R10", empty, m_occ == 0);
  endtask

  task automatic pick(input int pa, input int pc, input int pk, input int pf, input int psp);
    int cand[DEPTH];
    int nc;
    int r;
    alloc_valid = ($urandom % 100) < pa;
    r = $urandom % 8;
    alloc_kind = (r < 5) ? 2'b00 : (r < 7) ? 2'b01 : 2'b10;
    alloc_seq = seq_ctr;
    alloc_npc = $urandom & 32'hFFFF_FFFC;
    nc = 0;
    for (int k = 0; k < m_occ; k++) begin
      int s = (m_head + k) % DEPTH;
      if (!md[s] && (mkind[s] == 0 || mr[s])) begin cand[nc] = s; nc++; end
    end
    cmpl_valid = (nc > 0) && (($urandom % 100) < pc);
    cmpl_idx = (nc > 0) ? 3'(cand[$urandom % nc]) : 3'd0;
    cmpl_fault = ($urandom % 100) < pf;
    nc = 0;
    for (int k = 0; k < m_occ; k++) begin
      int s = (m_head + k) % DEPTH;
      if (!md[s] && !(cmpl_valid && 3'(s) == cmpl_idx)) begin cand[nc] = s; nc++; end
    end
    kill_valid = (nc > 0) && (($urandom % 100) < pk);
    kill_idx = (nc > 0) ? 3'(cand[$urandom % nc]) : 3'd0;
    stores_pending = ($urandom % 100) < psp;
    trap_lat = 4'($urandom % 4);
  endtask

  task automatic model_step();
    bit tsq, afire, stop, tt, rh;
    int pops, ret, tl, ridx;
    tsq = m_squash_now();
    afire = alloc_valid && m_occ != DEPTH && !m_pend;
    tl = (m_head + m_occ) % DEPTH;
    pops = 0; ret = 0; stop = 0; tt = 0; rh = 0; ridx = 0;
    x_killed = 0;
    for (int k = 0; k < m_occ; k++) begin
      int s = (m_head + k) % DEPTH;
      if (stop || m_pend) break;
      if (mk[s]) begin pops++; x_killed = 1; end
      else if (ret == WIDTH) stop = 1;
      else if (md[s] && mf[s]) begin tt = (ret == 0) && !stores_pending; stop = 1; end
      else if (md[s]) begin
        pops++; ret++;
        x_dseq = mseq[s]; x_pc = mnpc[s]; x_npc = mnpc[s] + INST_BYTES;
      end else begin
        if (mkind[s] != 0 && !mr[s] && (mkind[s] == 2 || (ret == 0 && !stores_pending))) begin
          rh = 1; ridx = s;
        end
        stop = 1;
      end
    end
    x_ret = ret; x_dv = ret != 0; x_rv = rh;
    if (rh) begin x_ridx = ridx; x_rkind = mkind[ridx]; end
    if (tsq) begin
      m_head = (m_head + m_occ) % DEPTH; m_occ = 0; m_pend = 0;
    end else begin
      m_head = (m_head + pops) % DEPTH; m_occ -= pops;
      if (tt) begin m_pend = 1; m_tc = trap_lat; end
      else if (m_pend) m_tc--;
    end
    if (cmpl_valid) begin md[cmpl_idx] = 1; mf[cmpl_idx] = cmpl_fault; end
    if (kill_valid) mk[kill_idx] = 1;
    if (rh) mr[ridx] = 1;
    if (afire) begin
      md[tl] = 0; mk[tl] = 0; mf[tl] = 0; mr[tl] = 0;
      mkind[tl] = (alloc_kind == 2'b10) ? 2 : (alloc_kind == 2'b00) ? 0 : 1;
      mseq[tl] = alloc_seq; mnpc[tl] = alloc_npc;
      m_occ++;
      seq_ctr++;
    end
  endtask

  task automatic run(input int cycles, input int pa, input int pc, input int pk,
                     input int pf, input int psp);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_outputs();
      pick(pa, pc, pk, pf, psp);
      model_step();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", alloc_ready, 1'b1);
    chk("R10", empty, 1'b1);
    chk("R10", full, 1'b0);
    chk("R5", arch_pc, RST_PC);
    chk("R5", arch_npc, RST_PC + 4);
    chk("R9", trap_pending, 1'b0);
    chk("R2", retire_cnt, 2'd0);
    pick(100, 0, 0, 0, 0);
    model_step();
    run(12, 100, 0, 0, 0, 0);
    run(30, 0, 100, 0, 0, 100);
    run(60, 40, 60, 0, 0, 0);
    run(3000, 60, 50, 8, 5, 40);
    run(1500, 70, 60, 5, 25, 30);
    run(800, 80, 70, 20, 0, 10);
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule